// File: doc/BRIEF.md
# Vector Table Lookup Permute

This unit builds a result vector by picking elements out of a data vector, steered by a second vector that holds one index per result element. The element width is chosen at run time from 8, 16, 32 or 64 bits. Index elements have the same width as data elements. An index that points past the last element gives a zero result element instead of wrapping around.

A caller presents the data vector, the index vector and a size code, and pulses the valid strobe. One clock later the registered result appears with its valid flag. The result stays unchanged until the next strobe. Every result element is taken from the vectors sampled at the strobe, so the caller may write the result back over the data register it came from. The vector width is a parameter and must be a multiple of 128 bits.

Top module: `tbl_permute`

## Requirements
- R1: The size code `esz_i` selects the element width: 0 for 8 bits, 1 for 16 bits, 2 for 32 bits, 3 for 64 bits. The element count is the vector width in bytes divided by the element width in bytes.
- R2: With 8-bit elements, result element i equals the data element whose number is held in index byte i.
- R3: With 16-bit elements, result element i equals the data element numbered by index halfword i.
- R4: With 32-bit and 64-bit elements, result element i equals the data element numbered by index element i of that width.
- R5: An index equal to or greater than the element count makes its result element zero. This includes an index exactly equal to the count.
- R6: Indices are compared as unsigned values over their full element width and are never truncated. An index whose upper bits are set, up to the all-ones value, gives zero even when its low bits name a valid element.
- R7: Element 0 occupies the least significant bits of every vector, and element k occupies bits [k*W +: W] for element width W.
- R8: `valid_o` is high exactly one clock after a cycle with `valid_i` high. The registered result is held unchanged while `valid_i` is low.
- R9: After reset, `valid_o` is 0 and `res_o` is all zeros.
- R10: All result elements are taken from the vectors sampled in the strobe cycle. Several result elements may select the same data element and all receive its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operand strobe |
| esz_i | input | 2 | Element size code |
| data_i | input | VLEN_BITS | Data vector (table) |
| idx_i | input | VLEN_BITS | Index vector |
| valid_o | output | 1 | Result valid, one clock after the strobe |
| res_o | output | VLEN_BITS | Permuted result vector |

## Verification
The bench builds the unit with a 256-bit vector instead of the 128-bit default. This gives 32 byte elements and 16 halfword elements, so indices 16 to 31 are valid for bytes but would be out of range at the default width. A design that fixes the count at 128 bits is therefore caught. At this width, halfword indices with bit 8 set while the low bits stay in range are possible, and these expose index truncation. A reference model covers all four sizes with directed boundary indices (count minus one, exactly the count, all ones) and with mixed in-range and out-of-range patterns.

// File: rtl/tbl_pkg.sv
package tbl_pkg;
  typedef enum logic [1:0] {
    ESZ_B = 2'd0,
    ESZ_H = 2'd1,
    ESZ_W = 2'd2,
    ESZ_D = 2'd3
  } esz_e;

  localparam int unsigned NUM_SIZES = 4;

  function automatic int unsigned esz_bits(int unsigned code);
    return 8 << code;
  endfunction
endpackage

// File: rtl/tbl_lane.sv
// Full-vector lookup for one fixed element width.
module tbl_lane #(
  parameter int unsigned VLEN_BITS = 128,
  parameter int unsigned EBITS     = 8
) (
  input  logic [VLEN_BITS-1:0] data_i,
  input  logic [VLEN_BITS-1:0] idx_i,
  output logic [VLEN_BITS-1:0] res_o
);
  localparam int unsigned NELEM = VLEN_BITS / EBITS;

  for (genvar i = 0; i < NELEM; i++) begin : g_elem
    logic [EBITS-1:0] idx_e;
    logic [EBITS-1:0] pick;
    assign idx_e = idx_i[i*EBITS +: EBITS];
    // full-width match: no element matches an out-of-range index, so it yields zero
    always_comb begin
      pick = '0;
      for (int j = 0; j < NELEM; j++) begin
        if (idx_e == EBITS'(j)) pick = data_i[j*EBITS +: EBITS];
      end
    end
    assign res_o[i*EBITS +: EBITS] = pick;
  end
endmodule

// File: rtl/tbl_core.sv
module tbl_core
  import tbl_pkg::*;
#(
  parameter int unsigned VLEN_BITS = 128
) (
  input  logic [1:0]           esz_i,
  input  logic [VLEN_BITS-1:0] data_i,
  input  logic [VLEN_BITS-1:0] idx_i,
  output logic [VLEN_BITS-1:0] res_o
);
  logic [VLEN_BITS-1:0] lane_res [NUM_SIZES];

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    tbl_lane #(
      .VLEN_BITS (VLEN_BITS),
      .EBITS     (esz_bits(s))
    ) lane_i (
      .data_i (data_i),
      .idx_i  (idx_i),
      .res_o  (lane_res[s])
    );
  end

  always_comb begin
    unique case (esz_e'(esz_i))
      ESZ_B:   res_o = lane_res[0];
      ESZ_H:   res_o = lane_res[1];
      ESZ_W:   res_o = lane_res[2];
      default: res_o = lane_res[3];
    endcase
  end
endmodule

// File: rtl/tbl_permute.sv
module tbl_permute #(
  parameter int unsigned VLEN_BITS = 128
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [1:0]           esz_i,
  input  logic [VLEN_BITS-1:0] data_i,
  input  logic [VLEN_BITS-1:0] idx_i,
  output logic                 valid_o,
  output logic [VLEN_BITS-1:0] res_o
);
  logic [VLEN_BITS-1:0] res_d;
  logic [VLEN_BITS-1:0] res_q;
  logic                 valid_q;

  tbl_core #(.VLEN_BITS(VLEN_BITS)) core_i (
    .esz_i  (esz_i),
    .data_i (data_i),
    .idx_i  (idx_i),
    .res_o  (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) res_q <= res_d;
    end
  end

  assign valid_o = valid_q;
  assign res_o   = res_q;
endmodule

// File: rtl/tbl_permute_chk.sv
module tbl_permute_chk #(
  parameter int unsigned VLEN_BITS = 128
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic [1:0]           esz_i,
  input logic [VLEN_BITS-1:0] data_i,
  input logic [VLEN_BITS-1:0] idx_i,
  input logic                 valid_o,
  input logic [VLEN_BITS-1:0] res_o
);
  localparam int unsigned NB = VLEN_BITS / 8;

  assert_valid_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o));
  assert_byte_lsb_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && esz_i == 2'd0 && idx_i[7:0] == 8'd1) |=> res_o[7:0] == $past(data_i[15:8]));
  assert_byte_oob_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && esz_i == 2'd0 && 32'(idx_i[7:0]) >= NB) |=> res_o[7:0] == 8'd0);
  assert_half_upper_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && esz_i == 2'd1 && idx_i[15:8] != 8'd0) |=> res_o[15:0] == 16'd0);
  assert_dword_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && esz_i == 2'd3 && idx_i[63:0] == 64'd0) |=> res_o[63:0] == $past(data_i[63:0]));
endmodule

bind tbl_permute tbl_permute_chk #(.VLEN_BITS(VLEN_BITS)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .esz_i   (esz_i),
  .data_i  (data_i),
  .idx_i   (idx_i),
  .valid_o (valid_o),
  .res_o   (res_o)
);

// File: tb/tbl_permute_tb.sv
module tbl_permute_tb_top;
  localparam int unsigned VW = 256;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned WATCHDOG = 20000;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [1:0]    esz_i = '0;
  logic [VW-1:0] data_i = '0;
  logic [VW-1:0] idx_i = '0;
  logic          valid_o;
  logic [VW-1:0] res_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tbl_permute #(.VLEN_BITS(VW)) dut_i (
    .clk_i (clk_i), .rst_ni (rst_ni), .valid_i (valid_i), .esz_i (esz_i),
    .data_i (data_i), .idx_i (idx_i), .valid_o (valid_o), .res_o (res_o)
  );

  function automatic int ebits(int sz);
    return 8 << sz;
  endfunction

  function automatic int nelem(int sz);
    return VW / (8 << sz);
  endfunction

  function automatic logic [VW-1:0] ref_tbl(logic [VW-1:0] d, logic [VW-1:0] x, int sz);
    logic [VW-1:0] r = '0;
    int eb = ebits(sz);
    int n = nelem(sz);
    for (int i = 0; i < n; i++) begin
      logic [63:0] iv = '0;
      for (int k = 0; k < eb; k++) iv[k] = x[i*eb+k];
      if (iv < 64'(n))
        for (int k = 0; k < eb; k++) r[i*eb+k] = d[int'(iv)*eb+k];
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] put_elem(logic [VW-1:0] v, int i, int sz, logic [63:0] val);
    int eb = ebits(sz);
    for (int k = 0; k < eb; k++) v[i*eb+k] = val[k];
    return v;
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] v;
    for (int w = 0; w < VW/32; w++) v[w*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(string req, logic [VW-1:0] got, logic [VW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic check_bit(string req, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  // drive one strobe, sample result half a cycle after the capturing edge
  task automatic run_op(string req, logic [VW-1:0] d, logic [VW-1:0] x, int sz);
    @(negedge clk_i);
    data_i = d; idx_i = x; esz_i = 2'(sz); valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    check_bit({req, "_valid"}, valid_o, 1'b1);
    check(req, res_o, ref_tbl(d, x, sz));
  endtask

  task automatic t_reset();
    check_bit("R9_valid", valid_o, 1'b0);
    check("R9_res", res_o, '0);
  endtask

  task automatic t_identity_reverse();
    for (int sz = 0; sz < 4; sz++) begin
      logic [VW-1:0] xi = '0;
      logic [VW-1:0] xr = '0;
      logic [VW-1:0] d = rnd_vec();
      for (int i = 0; i < nelem(sz); i++) begin
        xi = put_elem(xi, i, sz, 64'(i));
        xr = put_elem(xr, i, sz, 64'(nelem(sz) - 1 - i));
      end
      run_op("R1_R2_R3_R4_identity", d, xi, sz);
      check("R1_identity_eq_data", res_o, d);
      run_op("R2_R3_R4_reverse", d, xr, sz);
    end
  endtask

  task automatic t_boundary();
    for (int sz = 0; sz < 4; sz++) begin
      logic [VW-1:0] xc = '0;
      logic [VW-1:0] xl = '0;
      logic [VW-1:0] d = rnd_vec();
      for (int i = 0; i < nelem(sz); i++) begin
        xc = put_elem(xc, i, sz, 64'(nelem(sz)));
        xl = put_elem(xl, i, sz, 64'(nelem(sz) - 1));
      end
      run_op("R5_exact_count", d, xc, sz);
      check("R5_exact_count_zero", res_o, '0);
      run_op("R5_last_elem", d, xl, sz);
    end
  endtask

  task automatic t_upper_bits();
    for (int sz = 0; sz < 4; sz++) begin
      logic [VW-1:0] d = rnd_vec();
      run_op("R6_all_ones", d, '1, sz);
      check("R6_all_ones_zero", res_o, '0);
    end
    begin
      // halfword index 0x0103: low byte in range, bit 8 set
      logic [VW-1:0] d = rnd_vec();
      logic [VW-1:0] x = '0;
      for (int i = 0; i < nelem(1); i++) x = put_elem(x, i, 1, 64'h0103);
      run_op("R6_half_trunc", d, x, 1);
      check("R6_half_trunc_zero", res_o, '0);
      // doubleword index with only bit 32 set plus 1
      x = '0;
      for (int i = 0; i < nelem(3); i++) x = put_elem(x, i, 3, 64'h1_0000_0001);
      run_op("R6_dword_trunc", d, x, 3);
      check("R6_dword_trunc_zero", res_o, '0);
    end
  endtask

  task automatic t_little_endian();
    logic [VW-1:0] d = rnd_vec();
    logic [VW-1:0] x = '0;
    x = put_elem(x, 0, 0, 64'd1);
    x = put_elem(x, 1, 0, 64'd31);
    run_op("R7_le", d, x, 0);
    check("R7_le_byte0", {{(VW-8){1'b0}}, res_o[7:0]}, {{(VW-8){1'b0}}, d[15:8]});
    check("R7_le_byte1", {{(VW-8){1'b0}}, res_o[15:8]}, {{(VW-8){1'b0}}, d[255:248]});
  endtask

  task automatic t_hold();
    logic [VW-1:0] d = rnd_vec();
    logic [VW-1:0] snap;
    run_op("R8_first", d, rnd_vec(), 0);
    snap = res_o;
    data_i = rnd_vec(); idx_i = '0; esz_i = 2'd2;
    @(negedge clk_i);
    check_bit("R8_valid_drop", valid_o, 1'b0);
    check("R8_hold", res_o, snap);
    @(negedge clk_i);
    check("R8_hold2", res_o, snap);
  endtask

  task automatic t_broadcast();
    for (int sz = 0; sz < 4; sz++) begin
      logic [VW-1:0] d = rnd_vec();
      logic [VW-1:0] x = '0;
      for (int i = 0; i < nelem(sz); i++) x = put_elem(x, i, sz, 64'(1));
      run_op("R10_broadcast", d, x, sz);
      // use result as new data, mimicking write-back over the table
      run_op("R10_feedback", res_o, rnd_vec(), sz);
    end
  endtask

  task automatic t_random();
    for (int sz = 0; sz < 4; sz++)
      for (int r = 0; r < 40; r++) begin
        logic [VW-1:0] x = '0;
        for (int i = 0; i < nelem(sz); i++)
          x = put_elem(x, i, sz, 64'($urandom % (2 * nelem(sz))));
        run_op("R1_R2_R3_R4_R5_mixed", rnd_vec(), x, sz);
      end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog got=timeout exp=done");
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 2 + 3);
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_identity_reverse();
    t_boundary();
    t_upper_bits();
    t_little_endian();
    t_hold();
    t_broadcast();
    t_random();
    finish_run();
  end
endmodule